// File: doc/BRIEF.md
# Prescaled down-counting interrupt timer

A memory-mapped down-counting timer with four word registers on a simple synchronous register bus. Software writes a start value, selects a prescale divisor, and chooses between one-shot and periodic operation. While the timer is enabled, the counter steps down once per prescaled tick. When it reaches zero, a sticky event flag is set. That flag drives a level interrupt output, gated by an enable bit.

In one-shot use the counter stops at zero and raises the flag once. In periodic use the counter is refilled from the load register on the tick after zero, and counting goes on. Writing the load register also refills the live counter at once. Writing the counter register alone changes only the live count. Read data is combinational from the address, so a read returns the state left by the last clock edge.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Byte addresses select registers: 0x0 load value, 0x4 live counter, 0x8 control, 0xC status. Any other address reads zero. Control bit 0 is run enable, bit 1 is periodic reload and bit 2 is interrupt enable. Control bits [15:8] are the prescale divisor, and all other control bits read zero. Status bit 0 is the event flag, and the other status bits read zero.
- R3: The counter changes only on a tick while run enable is set, and it steps down by exactly one per tick. With run enable clear it holds its value.
- R4: A tick occurs every (divisor + 1) clock cycles; a divisor of 0 ticks on every enabled cycle. Any control write restarts the prescale phase, so the first decrement after a control write comes (divisor + 1) cycles after that write. No tick occurs in the cycle of the write.
- R5: With periodic reload clear, a counter at zero stays at zero on further ticks and does not set the event flag again.
- R6: With periodic reload set, a tick that finds the counter at zero refills it from the load register and sets the event flag.
- R7: A write to the load register sets both the load value and the live counter to the written data. A write to the counter register sets only the live counter. Either write takes priority over a tick in the same cycle, and counting then continues down from the written value.
- R8: A tick that moves the counter from 1 to 0 sets the event flag. The flag holds until a status write with bit 0 at 1 clears it. A status write with bit 0 at 0 leaves it unchanged.
- R9: When a flag-setting tick and a clearing status write fall in the same cycle, the flag ends up set.
- R10: `irq_o` is high exactly when the event flag and interrupt enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (4) | Byte address of the accessed register |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
A wrong prescale phase shows up as a counter readback that is early or late by whole ticks. This is visible from the first decrement after a control write, and the bench samples right at that boundary. An event flag that sets twice, sets too early or clears wrongly appears on the status register and on `irq_o` one edge after the offending tick or write. A broken reload is seen in the counter value on the tick after zero. A missed load-to-counter mirror shows in the very next counter read.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   // register byte offsets (behavioural: software decodes these)
   localparam int unsigned OFF_LOAD  = 0;
   localparam int unsigned OFF_COUNT = 4;
   localparam int unsigned OFF_CTRL  = 8;
   localparam int unsigned OFF_STAT  = 12;

   // control bit positions
   localparam int unsigned CTL_RUN_BIT  = 0;
   localparam int unsigned CTL_RLD_BIT  = 1;
   localparam int unsigned CTL_IRQE_BIT = 2;

   // status bit position
   localparam int unsigned STAT_FLAG_BIT = 0;

   typedef struct packed {
      logic irq_en;
      logic reload;
      logic run;
   } tmr_mode_t;
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
// Tick generator: one tick every (div + 1) enabled cycles; restarts on request.
module tmr_prescale #(
   parameter int unsigned PSC_W  = 8,
   localparam int unsigned PSC_VW = (PSC_W > 0) ? PSC_W : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              restart,
   input  logic [PSC_VW-1:0] div,
   output logic              tick
);
   generate
      if (PSC_W == 0) begin : g_nodiv
         // no divider: every enabled cycle is a tick
         assign tick = run & ~restart;
      end else begin : g_div
         logic [PSC_VW-1:0] phase_q;
         logic              at_end;

         assign at_end = (phase_q == div);
         assign tick   = run & at_end & ~restart;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= '0;
            end else if (restart || !run || at_end) begin
               phase_q <= '0;
            end else begin
               phase_q <= phase_q + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/tmr_count.sv
`timescale 1ns/1ps
// Load register and live down-counter with one-shot / periodic behaviour.
module tmr_count #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              reload,
   input  logic              load_wr,
   input  logic              cnt_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] load_q,
   output logic [DATA_W-1:0] cnt_q,
   output logic              evt
);
   localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
   localparam logic [DATA_W-1:0] ZERO = '0;

   logic              any_wr;
   logic              at_zero;
   logic [DATA_W-1:0] cnt_d;

   assign any_wr  = load_wr | cnt_wr;
   assign at_zero = (cnt_q == ZERO);

   // event: a 1->0 step, or a refill from zero in periodic mode
   assign evt = tick & ~any_wr & ((cnt_q == ONE) | (at_zero & reload));

   always_comb begin
      cnt_d = cnt_q;
      if (any_wr) begin
         cnt_d = wdata;
      end else if (tick) begin
         if (at_zero) begin
            cnt_d = reload ? load_q : ZERO;
         end else begin
            cnt_d = cnt_q - ONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         load_q <= '0;
      end else begin
         cnt_q <= cnt_d;
         if (load_wr) begin
            load_q <= wdata;
         end
      end
   end
endmodule

// File: rtl/tmr_flag.sv
`timescale 1ns/1ps
// Sticky event flag: set has priority over a write-one clear.
module tmr_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (set) begin
         flag_q <= 1'b1;
      end else if (clr) begin
         flag_q <= 1'b0;
      end
   end
endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
module tick_timer #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned PSC_W   = 8,
   parameter int unsigned PSC_LSB = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_o
);
   import tmr_pkg::*;

   localparam int unsigned PSC_VW = (PSC_W > 0) ? PSC_W : 1;
   localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(OFF_LOAD);
   localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFF_COUNT);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);

   // elaboration-time parameter checks
   generate
      if (DATA_W < 16) begin : g_chk_dw
         $error("tick_timer: DATA_W must be at least 16");
      end
      if (ADDR_W < 4) begin : g_chk_aw
         $error("tick_timer: ADDR_W must reach offset 0xC");
      end
      if (PSC_LSB < 3) begin : g_chk_lsb
         $error("tick_timer: divisor field overlaps mode bits");
      end
      if (PSC_LSB + PSC_VW > DATA_W) begin : g_chk_fit
         $error("tick_timer: divisor field exceeds data width");
      end
   endgenerate

   // write decode
   logic load_wr, cnt_wr, ctrl_wr, stat_wr;
   assign load_wr = reg_we & (reg_addr == A_LOAD);
   assign cnt_wr  = reg_we & (reg_addr == A_COUNT);
   assign ctrl_wr = reg_we & (reg_addr == A_CTRL);
   assign stat_wr = reg_we & (reg_addr == A_STAT);

   // control register
   tmr_mode_t         mode_q;
   logic [PSC_VW-1:0] div_q;
   logic              run_q, rld_q, ie_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         div_q  <= '0;
      end else if (ctrl_wr) begin
         mode_q.run    <= reg_wdata[CTL_RUN_BIT];
         mode_q.reload <= reg_wdata[CTL_RLD_BIT];
         mode_q.irq_en <= reg_wdata[CTL_IRQE_BIT];
         div_q         <= reg_wdata[PSC_LSB +: PSC_VW];
      end
   end

   assign run_q = mode_q.run;
   assign rld_q = mode_q.reload;
   assign ie_q  = mode_q.irq_en;

   // datapath
   logic              tick;
   logic              evt;
   logic              flag_q;
   logic [DATA_W-1:0] load_q;
   logic [DATA_W-1:0] cnt_q;

   tmr_prescale #(.PSC_W(PSC_W)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .restart (ctrl_wr),
      .div     (div_q),
      .tick    (tick)
   );

   tmr_count #(.DATA_W(DATA_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .reload  (rld_q),
      .load_wr (load_wr),
      .cnt_wr  (cnt_wr),
      .wdata   (reg_wdata),
      .load_q  (load_q),
      .cnt_q   (cnt_q),
      .evt     (evt)
   );

   tmr_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (evt),
      .clr    (stat_wr & reg_wdata[STAT_FLAG_BIT]),
      .flag_q (flag_q)
   );

   assign irq_o = flag_q & ie_q;

   // read path
   logic [DATA_W-1:0] div_field;
   generate
      if (PSC_W > 0) begin : g_div_rd
         assign div_field = DATA_W'(div_q) << PSC_LSB;
      end else begin : g_div_none
         assign div_field = '0;
      end
   endgenerate

   logic [DATA_W-1:0] ctrl_rd;
   always_comb begin
      ctrl_rd = div_field;
      ctrl_rd[CTL_RUN_BIT]  = run_q;
      ctrl_rd[CTL_RLD_BIT]  = rld_q;
      ctrl_rd[CTL_IRQE_BIT] = ie_q;
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         A_LOAD:  reg_rdata = load_q;
         A_COUNT: reg_rdata = cnt_q;
         A_CTRL:  reg_rdata = ctrl_rd;
         A_STAT:  reg_rdata[STAT_FLAG_BIT] = flag_q;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/tick_timer_chk.sv
`timescale 1ns/1ps
module tick_timer_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_we,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              irq_o,
   input logic              tick,
   input logic [DATA_W-1:0] cnt,
   input logic [DATA_W-1:0] load,
   input logic              flag,
   input logic              run,
   input logic              rld,
   input logic              ie
);
   import tmr_pkg::*;

   logic w_load, w_cnt, w_ctrl, w_stat;
   assign w_load = reg_we && (reg_addr == ADDR_W'(OFF_LOAD));
   assign w_cnt  = reg_we && (reg_addr == ADDR_W'(OFF_COUNT));
   assign w_ctrl = reg_we && (reg_addr == ADDR_W'(OFF_CTRL));
   assign w_stat = reg_we && (reg_addr == ADDR_W'(OFF_STAT));

   // R2: reserved control bits and upper status bits read zero
   p_ctrl_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(OFF_CTRL)) |-> (reg_rdata[7:3] == 5'd0 && reg_rdata[DATA_W-1:16] == '0));
   p_stat_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(OFF_STAT)) |-> (reg_rdata[DATA_W-1:1] == '0));

   // R3: disabled counter holds
   p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !w_cnt && !w_load && !w_ctrl) |=> $stable(cnt));
   // R3: a tick steps the counter down by one
   p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt > DATA_W'(1) && !w_cnt && !w_load) |=> (cnt == $past(cnt) - DATA_W'(1)));

   // R5: one-shot counter parked at zero stays and raises nothing
   p_park_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !rld && !w_cnt && !w_load) |=> (cnt == '0 && !$rose(flag)));

   // R6: periodic refill from zero
   p_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt == '0 && rld && !w_cnt && !w_load) |=> (cnt == $past(load) && flag));

   // R7: load write mirrors into the counter
   p_load_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
      w_load |=> (cnt == $past(reg_wdata) && load == $past(reg_wdata)));

   // R8: flag is sticky unless cleared by a one
   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !(w_stat && reg_wdata[0])) |=> flag);

   // R9: set beats clear
   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt == DATA_W'(1) && !w_cnt && !w_load) |=> flag);

   // R10: interrupt gating
   p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ie |-> !irq_o);
   p_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && ie) |-> irq_o);
endmodule

bind tick_timer tick_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_we    (reg_we),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .irq_o     (irq_o),
   .tick      (tick),
   .cnt       (cnt_q),
   .load      (load_q),
   .flag      (flag_q),
   .run       (run_q),
   .rld       (rld_q),
   .ie        (ie_q)
);

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;
   localparam int CLK_PERIOD = 10;
   localparam int QTR        = CLK_PERIOD / 4;
   localparam int DW         = 32;
   localparam int AW         = 4;

   localparam logic [AW-1:0] A_LOAD  = 4'h0;
   localparam logic [AW-1:0] A_COUNT = 4'h4;
   localparam logic [AW-1:0] A_CTRL  = 4'h8;
   localparam logic [AW-1:0] A_STAT  = 4'hC;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic          reg_we = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          irq_o;

   int checks = 0;
   int errors = 0;

   logic [DW-1:0] exp_q[$];
   string         tag_q[$];
   logic          rd_vld = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tick_timer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_o     (irq_o)
   );

   // monitor: compares read data against the scoreboard queue
   always @(negedge clk) begin
      #(QTR);
      if (rd_vld && exp_q.size() > 0) begin
         logic [DW-1:0] e;
         string         t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (reg_rdata !== e) begin
            errors++;
            $display("FAIL %s: rdata=0x%08h expected 0x%08h", t, reg_rdata, e);
         end
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_we    = 1'b1;
      @(posedge clk);
      #1;
      reg_we    = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
      @(negedge clk);
      reg_addr = a;
      exp_q.push_back(e);
      tag_q.push_back(t);
      rd_vld = 1'b1;
      @(posedge clk);
      #1;
      rd_vld = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string t);
      @(negedge clk);
      #(QTR);
      checks++;
      if (irq_o !== e) begin
         errors++;
         $display("FAIL %s: irq_o=%0b expected %0b", t, irq_o, e);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values
      rd(A_LOAD,  32'h0, "R1 load after reset");
      rd(A_COUNT, 32'h0, "R1 counter after reset");
      rd(A_CTRL,  32'h0, "R1 control after reset");
      rd(A_STAT,  32'h0, "R1 status after reset");
      chk_irq(1'b0, "R1 irq after reset");

      // R2: control layout and unmapped address
      wr(A_CTRL, 32'hFFFF_FFFF);
      rd(A_CTRL, 32'h0000_FF07, "R2 control readback masks reserved bits");
      wr(A_CTRL, 32'h0);
      rd(4'h1, 32'h0, "R2 unmapped address reads zero");

      // R7: load mirrors into counter; counter write leaves load
      wr(A_LOAD, 32'd5);
      rd(A_COUNT, 32'd5, "R7 load write sets counter");
      rd(A_LOAD,  32'd5, "R7 load value");
      wr(A_COUNT, 32'd9);
      rd(A_COUNT, 32'd9, "R7 counter write");
      rd(A_LOAD,  32'd5, "R7 counter write leaves load");

      // R3: disabled hold
      idle(10);
      rd(A_COUNT, 32'd9, "R3 disabled counter holds");

      // R3/R4: divisor 0 counts every cycle
      wr(A_COUNT, 32'd100);
      wr(A_CTRL, 32'h0000_0001);
      rd(A_COUNT, 32'd100, "R4 no decrement on control write edge");
      rd(A_COUNT, 32'd99,  "R3 first decrement");
      rd(A_COUNT, 32'd98,  "R3 second decrement");
      idle(5);
      rd(A_COUNT, 32'd92,  "R3 running count");
      wr(A_CTRL, 32'h0);
      rd(A_COUNT, 32'd91,  "R3 stop holds value");

      // R4: divisor 3 and phase restart
      wr(A_COUNT, 32'd50);
      wr(A_CTRL, 32'h0000_0301);
      rd(A_COUNT, 32'd50, "R4 div3 phase 0");
      rd(A_COUNT, 32'd50, "R4 div3 phase 1");
      rd(A_COUNT, 32'd50, "R4 div3 phase 2");
      rd(A_COUNT, 32'd50, "R4 div3 phase 3");
      rd(A_COUNT, 32'd49, "R4 div3 first tick");
      wr(A_CTRL, 32'h0000_0301);
      rd(A_COUNT, 32'd49, "R4 restart phase 0");
      rd(A_COUNT, 32'd49, "R4 restart phase 1");
      rd(A_COUNT, 32'd49, "R4 restart phase 2");
      rd(A_COUNT, 32'd49, "R4 restart phase 3");
      rd(A_COUNT, 32'd48, "R4 tick after restart");
      wr(A_CTRL, 32'h0);
      rd(A_COUNT, 32'd48, "R4 stop");

      // R5/R8/R10: one-shot with interrupt
      wr(A_COUNT, 32'd3);
      wr(A_CTRL, 32'h0000_0005);
      idle(6);
      rd(A_COUNT, 32'd0, "R5 one-shot stops at zero");
      rd(A_STAT,  32'd1, "R8 flag set on reaching zero");
      chk_irq(1'b1, "R10 irq with flag and enable");
      wr(A_STAT, 32'h0000_0000);
      rd(A_STAT, 32'd1, "R8 write zero leaves flag");
      wr(A_STAT, 32'h0000_0001);
      rd(A_STAT, 32'd0, "R8 write one clears flag");
      chk_irq(1'b0, "R10 irq drops with flag");
      idle(10);
      rd(A_COUNT, 32'd0, "R5 parked at zero");
      rd(A_STAT,  32'd0, "R5 no repeat event at zero");
      wr(A_CTRL, 32'h0);

      // R6/R10: periodic reload, interrupt disabled
      wr(A_LOAD, 32'd2);
      wr(A_CTRL, 32'h0000_0003);
      rd(A_COUNT, 32'd2, "R6 start");
      rd(A_COUNT, 32'd1, "R6 step");
      rd(A_COUNT, 32'd0, "R6 zero");
      rd(A_COUNT, 32'd2, "R6 refill from load");
      rd(A_COUNT, 32'd1, "R6 continues after refill");
      rd(A_STAT,  32'd1, "R6 event flag set");
      chk_irq(1'b0, "R10 irq gated off by enable");
      wr(A_CTRL, 32'h0);

      // R9: set beats clear in the same cycle
      wr(A_STAT, 32'h1);
      rd(A_STAT, 32'd0, "R9 setup clear");
      wr(A_COUNT, 32'd3);
      wr(A_CTRL, 32'h0000_0001);
      idle(2);
      wr(A_STAT, 32'h1);
      rd(A_STAT,  32'd1, "R9 set wins over clear");
      rd(A_COUNT, 32'd0, "R9 counter at zero");
      wr(A_CTRL, 32'h0);

      // R7: counter write while running resumes from new value
      wr(A_CTRL, 32'h0000_0001);
      wr(A_COUNT, 32'd20);
      rd(A_COUNT, 32'd20, "R7 write beats tick");
      rd(A_COUNT, 32'd19, "R7 resumes from written value");
      wr(A_CTRL, 32'h0);

      idle(3);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule